// File: doc/BRIEF.md
# Host Port Data Access Slave

This block lets an external host reach a 32-bit internal data word through a 16-bit port that works with strobes, not with a clock. The host drives a chip select, two data strobes, a read/write select, a two-bit access selector and a half-word select. It uses a shared 16-bit data bus. A wait output tells the host when to hold its strobe low. All of the host's signals, including the data bus, pass through two-flop synchronizers into the internal clock domain. The effective strobe is built from the synchronized chip select and the two data strobes. Falling and rising edges of that strobe then drive every action.

On the internal side, a read of the first half-word of the data word raises a request on a request/acknowledge port. The host is made to wait until the fetched word has been loaded. The second half-word comes from the word already held, so it needs no fetch. Writes collect both halves and push the full word to an external write buffer. The host is stalled whenever that buffer reports full. Accesses with a non-data selector go to a decode stub. The stub reads back zero and ignores writes.

Top module: `hostport_slave`

## Requirements
- R1: The effective strobe is active (low) only while chip select is low and exactly one of the two data strobes is low. Either strobe alone can carry an access. With both strobes low, or with chip select high, no fetch, push or bus drive happens.
- R2: The read/write select, selector and half-word select are latched when the strobe falls. Changing them while the strobe stays low does not change the access in progress.
- R3: Half-word select 0 addresses bits 15:0 and 1 addresses bits 31:16. Write data is taken on the strobe's rising edge. One push of {high half, low half} happens on the high-half write only if a low-half write came before it since the last push. A high-half write with no low half before it pushes nothing.
- R4: A read with selector 2'b11 (data) and half-word select 0 issues exactly one memory request when the strobe falls. The request is held until acknowledge, and the wait output stays high until the returned word is loaded. The read then returns bits 15:0 of that word.
- R5: A data read with half-word select 1 returns bits 31:16 of the held word. It issues no request and leaves the wait output low.
- R6: A data write that starts while the buffer-full input is high raises the wait output until full drops. With full low, a write causes no wait.
- R7: The block drives the data bus only from the strobe's fall until its rise during a read. At all other times, and during writes, the bus is left undriven.
- R8: The wait output goes high once the synchronized chip select falls, before any strobe. It clears on the next strobe fall unless R4 or R6 stalls the access.
- R9: Selector values other than 2'b11 read back 0x0000 and issue no request. Writes with those values push nothing and leave the data word unchanged.
- R10: After reset, the wait output, the memory request and the push are low and the bus is undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hp_cs_n | input | 1 | Host chip select, active low |
| hp_ds1_n | input | 1 | Host data strobe one |
| hp_ds2_n | input | 1 | Host data strobe two |
| hp_rnw | input | 1 | Host read (1) / write (0) select |
| hp_sel | input | 2 | Access selector, 2'b11 = data word |
| hp_half | input | 1 | Half-word select, 0 = low, 1 = high |
| hp_data | inout | 16 | Shared host data bus |
| hp_wait | output | 1 | High tells the host to keep waiting |
| mem_rd_req | output | 1 | Fetch request, held until acknowledge |
| mem_rd_ack | input | 1 | One-cycle fetch acknowledge |
| mem_rd_data | input | 32 | Fetched word, valid with acknowledge |
| wbuf_push | output | 1 | One-cycle push of an assembled word |
| wbuf_data | output | 32 | Word being pushed |
| wbuf_full | input | 1 | Write buffer full |

## Verification
The hardest states to reach are the ones where the host changes something mid-access. One is a select change while the strobe is still low. Another is a write that is held off by a full buffer. The bench reaches both with split tasks that lower the strobe, act on the other inputs over several cycles, and only then raise it. A memory responder with a long, fixed latency keeps the fetch stall open long enough to see the wait output high. The bus has a pulldown, so any sample taken while the block is not driving reads zero. This makes driving at the wrong time visible against non-zero data words.

// File: rtl/hps_pkg.sv
// Package: shared types for the host port slave.
// Assumes the selector encoding below is fixed by the host protocol.
package hps_pkg;
    typedef enum logic [1:0] {
        SEL_CTRL  = 2'b00,
        SEL_ADRI  = 2'b01,
        SEL_ADR   = 2'b10,
        SEL_DATA  = 2'b11
    } hps_sel_e;

    typedef struct packed {
        logic     rnw;
        hps_sel_e sel;
        logic     half;
    } hps_xfer_t;
endpackage

// File: rtl/hps_sync.sv
// Module: multi-stage synchronizer for asynchronous host inputs.
// Assumes each bit may be sampled independently; multi-bit fields are
// only used after a strobe edge that arrives through the same depth.
module hps_sync #(
    parameter int           W       = 1,
    parameter int           DEPTH   = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [DEPTH];

    // shift the input through DEPTH flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[DEPTH-1];
endmodule

// File: rtl/hps_strobe.sv
// Module: derives the effective host strobe and detects its edges and
// the chip-select fall. Inputs must already be synchronized.
module hps_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic ds1_n,
    input  logic ds2_n,
    output logic stb_fall,
    output logic stb_rise,
    output logic cs_fall
);
    logic stb_n;
    logic stb_q;
    logic cs_q;

    // strobe active only with select low and exactly one strobe low
    assign stb_n = ~(ds1_n ^ ds2_n) | cs_n;

    // remember previous strobe and select levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q <= 1'b1;
            cs_q  <= 1'b1;
        end else begin
            stb_q <= stb_n;
            cs_q  <= cs_n;
        end
    end

    assign stb_fall = stb_q & ~stb_n;
    assign stb_rise = ~stb_q & stb_n;
    assign cs_fall  = cs_q & ~cs_n;
endmodule

// File: rtl/hps_dataword.sv
// Module: holds the data word, loads fetched words, assembles written
// halves and emits one push per completed low+high pair.
// Assumes load and write never occur in the same cycle.
module hps_dataword #(
    parameter int HALF_W = 16,
    localparam int WORD_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_data,
    input  logic              wr_en,
    input  logic              wr_half,
    input  logic [HALF_W-1:0] wr_din,
    input  logic              rd_half,
    output logic [HALF_W-1:0] rd_dout,
    output logic              push,
    output logic [WORD_W-1:0] push_data
);
    logic [WORD_W-1:0] word_q;
    logic              lo_seen;

    // update the word from a fetch or from a host half-word write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (load) begin
            word_q <= load_data;
        end else if (wr_en) begin
            if (wr_half) word_q[WORD_W-1:HALF_W] <= wr_din;
            else         word_q[HALF_W-1:0]      <= wr_din;
        end
    end

    // track the low half and pulse push when the high half completes it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_seen <= 1'b0;
            push    <= 1'b0;
        end else begin
            push <= wr_en & wr_half & lo_seen;
            if (wr_en) lo_seen <= ~wr_half;
        end
    end

    assign push_data = word_q;
    assign rd_dout   = rd_half ? word_q[WORD_W-1:HALF_W] : word_q[HALF_W-1:0];
endmodule

// File: rtl/hostport_slave.sv
// Module: top of the host port slave. Synchronizes host inputs, latches
// the access on strobe fall, controls fetch, write stall, wait output
// and bus drive. Assumes the host holds write data until the rising
// strobe has been seen (synchronizer depth plus one cycle).
module hostport_slave
    import hps_pkg::*;
#(
    parameter int HALF_W     = 16,
    parameter int SYNC_DEPTH = 2,
    localparam int WORD_W    = 2 * HALF_W,
    localparam int CTL_W     = $bits(hps_xfer_t) + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hp_cs_n,
    input  logic              hp_ds1_n,
    input  logic              hp_ds2_n,
    input  logic              hp_rnw,
    input  logic [1:0]        hp_sel,
    input  logic              hp_half,
    inout  wire  [HALF_W-1:0] hp_data,
    output logic              hp_wait,
    output logic              mem_rd_req,
    input  logic              mem_rd_ack,
    input  logic [WORD_W-1:0] mem_rd_data,
    output logic              wbuf_push,
    output logic [WORD_W-1:0] wbuf_data,
    input  logic              wbuf_full
);
    logic [CTL_W-1:0]  ctl_s;
    logic [HALF_W-1:0] din_s;
    logic              cs_idle, ds1_s, ds2_s;
    hps_xfer_t         xfer_s, xfer_q;
    logic              stb_fall, stb_rise, cs_fall;
    logic              cs_hold, fetch_busy, full_stall, bus_oe;
    logic              is_data, wr_en;
    logic [HALF_W-1:0] rd_half_val;

    hps_sync #(.W(CTL_W), .DEPTH(SYNC_DEPTH), .RST_VAL({CTL_W{1'b1}})) u_sync_ctl (
        .clk(clk), .rst_n(rst_n),
        .d({hp_cs_n, hp_ds1_n, hp_ds2_n, hp_rnw, hp_sel, hp_half}),
        .q(ctl_s)
    );

    hps_sync #(.W(HALF_W), .DEPTH(SYNC_DEPTH), .RST_VAL('0)) u_sync_dat (
        .clk(clk), .rst_n(rst_n), .d(hp_data), .q(din_s)
    );

    assign {cs_idle, ds1_s, ds2_s} = ctl_s[CTL_W-1 -: 3];
    assign xfer_s = hps_xfer_t'(ctl_s[$bits(hps_xfer_t)-1:0]);

    hps_strobe u_strobe (
        .clk(clk), .rst_n(rst_n),
        .cs_n(cs_idle), .ds1_n(ds1_s), .ds2_n(ds2_s),
        .stb_fall(stb_fall), .stb_rise(stb_rise), .cs_fall(cs_fall)
    );

    assign is_data = (xfer_s.sel == SEL_DATA);

    // latch the access selects on strobe fall
    always_ff @(posedge clk) begin
        if (!rst_n)        xfer_q <= '{rnw: 1'b1, sel: SEL_CTRL, half: 1'b0};
        else if (stb_fall) xfer_q <= xfer_s;
    end

    // wait from chip-select fall until the first strobe is taken
    always_ff @(posedge clk) begin
        if (!rst_n || cs_idle) cs_hold <= 1'b0;
        else if (cs_fall)      cs_hold <= 1'b1;
        else if (stb_fall)     cs_hold <= 1'b0;
    end

    // fetch request for a low-half data read, held until acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)
            fetch_busy <= 1'b0;
        else if (fetch_busy && mem_rd_ack)
            fetch_busy <= 1'b0;
        else if (stb_fall && xfer_s.rnw && is_data && !xfer_s.half)
            fetch_busy <= 1'b1;
    end

    // stall a data write while the write buffer is full
    always_ff @(posedge clk) begin
        if (!rst_n || cs_idle || !wbuf_full)
            full_stall <= 1'b0;
        else if (stb_fall && !xfer_s.rnw && is_data)
            full_stall <= 1'b1;
    end

    // drive the bus between strobe fall and rise of a read
    always_ff @(posedge clk) begin
        if (!rst_n || cs_idle || stb_rise) bus_oe <= 1'b0;
        else if (stb_fall)                 bus_oe <= xfer_s.rnw;
    end

    assign wr_en = stb_rise && !xfer_q.rnw && (xfer_q.sel == SEL_DATA);

    hps_dataword #(.HALF_W(HALF_W)) u_word (
        .clk(clk), .rst_n(rst_n),
        .load(fetch_busy && mem_rd_ack), .load_data(mem_rd_data),
        .wr_en(wr_en), .wr_half(xfer_q.half), .wr_din(din_s),
        .rd_half(xfer_q.half), .rd_dout(rd_half_val),
        .push(wbuf_push), .push_data(wbuf_data)
    );

    assign mem_rd_req = fetch_busy;
    assign hp_wait    = cs_hold | fetch_busy | full_stall;
    assign hp_data    = bus_oe ? ((xfer_q.sel == SEL_DATA) ? rd_half_val : '0)
                               : 'z;
endmodule

// File: rtl/hostport_slave_chk.sv
// Module: protocol checker for hostport_slave, attached by bind.
module hostport_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic hp_wait,
    input logic mem_rd_req,
    input logic mem_rd_ack,
    input logic wbuf_push,
    input logic bus_oe,
    input logic rd_latched,
    input logic cs_idle
);
    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req && !mem_rd_ack |=> mem_rd_req);
    // R4
    req_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> hp_wait);
    // R4
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req && mem_rd_ack |=> !mem_rd_req);
    // R3
    push_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wbuf_push |=> !wbuf_push);
    // R7
    oe_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> rd_latched);
    // R8
    idle_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_idle && !mem_rd_req |=> !hp_wait);
endmodule

bind hostport_slave hostport_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .hp_wait(hp_wait),
    .mem_rd_req(mem_rd_req), .mem_rd_ack(mem_rd_ack),
    .wbuf_push(wbuf_push), .bus_oe(bus_oe),
    .rd_latched(xfer_q.rnw), .cs_idle(cs_idle)
);

// File: tb/hostport_slave_tb.sv
module hostport_slave_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, ds1_n = 1'b1, ds2_n = 1'b1, rnw = 1'b1, half = 1'b0;
    logic [1:0]  sel = 2'b11;
    wire  [15:0] hp_data;
    logic        host_oe = 1'b0;
    logic [15:0] host_val = '0;
    logic        hp_wait, mem_rd_req, wbuf_push;
    logic        mem_rd_ack = 1'b0, wbuf_full = 1'b0;
    logic [31:0] mem_rd_data = '0, wbuf_data;
    logic [31:0] mem_word = 32'hCAFE_5A5A, last_push = '0;
    int          mem_lat = 20, req_cnt = 0, push_cnt = 0;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    assign hp_data = host_oe ? host_val : 16'hzzzz;
    for (genvar i = 0; i < 16; i++) begin : g_pd
        pulldown pd_i (hp_data[i]);
    end

    hostport_slave u_dut (
        .clk(clk), .rst_n(rst_n), .hp_cs_n(cs_n), .hp_ds1_n(ds1_n),
        .hp_ds2_n(ds2_n), .hp_rnw(rnw), .hp_sel(sel), .hp_half(half),
        .hp_data(hp_data), .hp_wait(hp_wait), .mem_rd_req(mem_rd_req),
        .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data),
        .wbuf_push(wbuf_push), .wbuf_data(wbuf_data), .wbuf_full(wbuf_full)
    );

    // memory responder: counts requests, answers after mem_lat cycles
    initial forever begin
        @(negedge clk);
        if (mem_rd_req) begin
            req_cnt++;
            repeat (mem_lat) @(negedge clk);
            mem_rd_data = mem_word;
            mem_rd_ack  = 1'b1;
            @(negedge clk);
            mem_rd_ack  = 1'b0;
        end
    end

    // push monitor
    initial forever begin
        @(negedge clk);
        if (wbuf_push) begin
            push_cnt++;
            last_push = wbuf_data;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic stb_low(input int which);
        if (which == 1 || which == 3) ds1_n = 1'b0;
        if (which == 2 || which == 3) ds2_n = 1'b0;
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 200 && hp_wait; i++) @(negedge clk);
    endtask

    // complete access with the given strobe choice; returns bus value
    task automatic access(input logic r, input logic [1:0] s, input logic h,
                          input logic [15:0] wd, input int which,
                          output logic [15:0] rd);
        rnw = r; sel = s; half = h;
        host_oe = !r; host_val = wd;
        cyc(3);
        stb_low(which);
        cyc(5);
        wait_ready();
        cyc(2);
        rd = hp_data;
        ds1_n = 1'b1; ds2_n = 1'b1;
        cyc(6);
        host_oe = 1'b0;
        cyc(3);
    endtask

    task automatic t_reset();
        check("R10 wait", hp_wait, 0);
        check("R10 req", mem_rd_req, 0);
        check("R10 push", wbuf_push, 0);
        check("R10 bus", hp_data, 16'h0000);
    endtask

    task automatic t_cs_wait();
        cs_n = 1'b0;
        cyc(5);
        check("R8 wait on select", hp_wait, 1);
    endtask

    task automatic t_fetch();
        logic [15:0] rd;
        rnw = 1'b1; sel = 2'b11; half = 1'b0;
        cyc(3);
        check("R7 bus idle before read", hp_data, 16'h0000);
        stb_low(1);
        cyc(6);
        check("R4 wait during fetch", hp_wait, 1);
        check("R4 one request", req_cnt, 1);
        wait_ready();
        cyc(2);
        check("R4 low half", hp_data, 16'h5A5A);
        ds1_n = 1'b1;
        cyc(6);
        check("R7 bus released", hp_data, 16'h0000);
        check("R4 request count", req_cnt, 1);
        rnw = 1'b1; half = 1'b1;
        cyc(3);
        stb_low(1);
        cyc(6);
        check("R5 no wait", hp_wait, 0);
        check("R5 high half", hp_data, 16'hCAFE);
        ds1_n = 1'b1;
        cyc(6);
        check("R5 no request", req_cnt, 1);
        access(1'b1, 2'b11, 1'b1, 16'h0, 2, rd);
        check("R1 second strobe reads", rd, 16'hCAFE);
    endtask

    task automatic t_latch();
        rnw = 1'b1; sel = 2'b11; half = 1'b1;
        cyc(3);
        stb_low(1);
        cyc(3);
        half = 1'b0;
        cyc(8);
        check("R2 latched half", hp_data, 16'hCAFE);
        ds1_n = 1'b1;
        cyc(6);
        check("R2 no fetch", req_cnt, 1);
    endtask

    task automatic t_both_strobes();
        logic [15:0] rd;
        rnw = 1'b1; sel = 2'b11; half = 1'b0;
        cyc(3);
        stb_low(3);
        cyc(8);
        check("R1 both low no request", req_cnt, 1);
        check("R1 both low no drive", hp_data, 16'h0000);
        ds1_n = 1'b1; ds2_n = 1'b1;
        cyc(4);
        access(1'b1, 2'b11, 1'b1, 16'h0, 1, rd);
        check("R1 normal access after", rd, 16'hCAFE);
    endtask

    task automatic t_stub();
        logic [15:0] rd;
        access(1'b1, 2'b00, 1'b0, 16'h0, 1, rd);
        check("R9 stub reads zero", rd, 16'h0000);
        check("R9 stub no request", req_cnt, 1);
        access(1'b0, 2'b01, 1'b0, 16'h1111, 1, rd);
        access(1'b0, 2'b01, 1'b1, 16'h2222, 1, rd);
        check("R9 stub no push", push_cnt, 0);
        access(1'b1, 2'b11, 1'b1, 16'h0, 1, rd);
        check("R9 word unchanged", rd, 16'hCAFE);
    endtask

    task automatic t_write();
        logic [15:0] rd;
        access(1'b0, 2'b11, 1'b0, 16'h1234, 1, rd);
        check("R3 low half alone no push", push_cnt, 0);
        check("R6 no wait when not full", hp_wait, 0);
        access(1'b0, 2'b11, 1'b1, 16'hABCD, 2, rd);
        check("R3 push count", push_cnt, 1);
        check("R3 pushed word", last_push, 32'hABCD_1234);
        check("R7 bus idle after write", hp_data, 16'h0000);
        access(1'b0, 2'b11, 1'b1, 16'h7777, 1, rd);
        check("R3 high half alone no push", push_cnt, 1);
    endtask

    task automatic t_full();
        logic [15:0] rd;
        wbuf_full = 1'b1;
        rnw = 1'b0; sel = 2'b11; half = 1'b0;
        host_oe = 1'b1; host_val = 16'h0F0F;
        cyc(3);
        stb_low(1);
        cyc(6);
        check("R6 wait while full", hp_wait, 1);
        cyc(10);
        check("R6 still waiting", hp_wait, 1);
        wbuf_full = 1'b0;
        cyc(4);
        check("R6 wait cleared", hp_wait, 0);
        ds1_n = 1'b1;
        cyc(6);
        host_oe = 1'b0;
        cyc(3);
        access(1'b0, 2'b11, 1'b1, 16'hF0F0, 1, rd);
        check("R6 stalled write pushed", last_push, 32'hF0F0_0F0F);
        check("R6 push count", push_cnt, 2);
    endtask

    initial begin
        cyc(4);
        t_reset();
        rst_n = 1'b1;
        cyc(3);
        t_cs_wait();
        t_fetch();
        t_latch();
        t_both_strobes();
        t_stub();
        t_write();
        t_full();
        cs_n = 1'b1;
        cyc(5);
        check("R8 wait low when deselected", hp_wait, 0);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule